// File: doc/BRIEF.md
# Masked Abort Multiplicity Poller

This block gathers abort requests from a shared backplane bus on which many loss-monitor channels sit behind a 6-bit channel select. Each measurement strobe starts one polling pass. The block presents each channel address in turn and reads back four active-low request lines, one for each abort type, together with a channel-healthy line. For each type it counts the channels that are requesting that type and that the type's per-channel enable mask admits. At the end of the pass it compares each count with a multiplicity threshold and drives four abort flags and their OR.

Enable masks and thresholds are written into a staging copy. They are loaded into the working copy only on an update pulse, so a new machine state's settings can be written piece by piece without disturbing a pass. During each pass the block also emits a packed record for an external circular history memory. The record holds one status word for every four channels, followed by two summary words.

Top module: `abort_mult_poller`

## Requirements
- R1: While idle, `chan_sel` holds 0. A `meas_stb` pulse seen while idle starts a pass. On the next NCH clocks `chan_sel` steps 0, 1, …, NCH-1, one address per clock, and `abort_n`/`chan_ok` are sampled in the same clock the address is presented.
- R2: A channel requests type t by driving `abort_n[t]` low. It adds to the count for type t only when bit [channel] of the working mask for type t is 1 and `chan_ok` is high.
- R3: When a pass completes, `abort_out[t]` is 1 exactly when count[t] ≥ working threshold[t]. A threshold of 0 therefore always asserts. `abort_any` is the OR of `abort_out`.
- R4: Each count saturates at 63 and does not wrap.
- R5: A channel sampled with `chan_ok` low contributes nothing to any count or status bit. `svc_irq` is updated at pass completion to 1 if any channel in that pass was not healthy, and to 0 otherwise.
- R6: `set_we` writes `set_mask` and `set_mult` into the staging entry of type `set_type`. The working copy is unchanged until `upd_stb`, which copies all four staged entries. After reset, both copies hold masks of 0 and thresholds of 63.
- R7: History status word k (`hist_addr` = k, k = 0 … NCH/4-1) covers channels 4k … 4k+3. Bit 4·(ch−4k)+t holds the request of type t from a healthy channel, regardless of mask. Types are ordered 0 immediate, 1 fast, 2 slow, 3 very slow. Word k is written one clock after channel 4k+3 is sampled.
- R8: The summary words follow at `hist_addr` NCH/4 and NCH/4+1. The first holds the four abort flags in bits 3:0, count[0] in bits 9:4 and count[1] in bits 15:10. The second holds zeros in bits 3:0, count[2] in bits 9:4 and count[3] in bits 15:10.
- R9: `abort_out`, `abort_any` and `svc_irq` change only when the first summary word is written, and hold between passes. A `meas_stb` arriving during a pass is ignored, and exactly NCH/4+2 history words are written per pass.
- R10: In reset, `chan_sel`, `abort_out`, `abort_any`, `svc_irq` and `hist_we` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| meas_stb | input | 1 | Measurement strobe, starts a pass when idle |
| upd_stb | input | 1 | Copies staged settings to working settings |
| set_we | input | 1 | Staging write enable |
| set_type | input | 2 | Abort type addressed by a staging write |
| set_mask | input | NCH | Channel enable mask for that type |
| set_mult | input | 6 | Multiplicity threshold for that type |
| chan_sel | output | log2(NCH) | Polled channel address |
| abort_n | input | 4 | Active-low requests of the selected channel |
| chan_ok | input | 1 | Selected channel healthy |
| abort_out | output | 4 | Abort flags per type |
| abort_any | output | 1 | OR of abort flags |
| svc_irq | output | 1 | Unhealthy channel seen in last pass |
| hist_we | output | 1 | History word valid |
| hist_addr | output | log2(NCH/4+2) | Word index within the record |
| hist_data | output | 16 | History word |

## Verification
The bench builds the block with its default of 64 channels. This is one more than the largest 6-bit count, so a pass in which every channel requests every enabled type drives the counters into saturation. It also puts a full sixteen status words in front of the summary pair, which exercises channel-group boundaries at both ends of the address range. The channel bus model answers combinationally from the presented address, so each sampled value ties to a known channel number. Threshold cases cover equality, one above the count, zero, and the maximum.

// File: rtl/abort_mult_poller.sv
module abort_mult_poller #(
  parameter int NCH = 64
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           meas_stb,
  input  logic                           upd_stb,
  input  logic                           set_we,
  input  logic [1:0]                     set_type,
  input  logic [NCH-1:0]                 set_mask,
  input  logic [5:0]                     set_mult,
  output logic [$clog2(NCH)-1:0]         chan_sel,
  input  logic [3:0]                     abort_n,
  input  logic                           chan_ok,
  output logic [3:0]                     abort_out,
  output logic                           abort_any,
  output logic                           svc_irq,
  output logic                           hist_we,
  output logic [$clog2(NCH/4+2)-1:0]     hist_addr,
  output logic [15:0]                    hist_data
);
  localparam int SELW = $clog2(NCH);
  localparam int NGRP = NCH / 4;
  localparam int AW   = $clog2(NGRP + 2);
  localparam logic [5:0] CMAX = 6'h3f;

  typedef enum logic [1:0] {IDLE, SCAN, SUM1, SUM2} st_t;
  st_t state;

  logic [NCH-1:0] mask_set [4];
  logic [NCH-1:0] mask_act [4];
  logic [5:0]     mult_set [4];
  logic [5:0]     mult_act [4];
  logic [5:0]     cnt      [4];
  logic [SELW-1:0] sel;
  logic [15:0]    stat;
  logic           bad_seen;
  logic           scanning;
  logic [3:0]     req_ok;
  logic [3:0]     hit;
  logic [3:0]     ab_next;

  assign scanning = (state == SCAN);
  assign chan_sel = sel;
  assign req_ok   = chan_ok ? ~abort_n : 4'b0000;

  for (genvar t = 0; t < 4; t++) begin : g_type
    assign hit[t]     = req_ok[t] & mask_act[t][sel];
    assign ab_next[t] = (cnt[t] >= mult_act[t]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin
        mask_set[i] <= '0;
        mask_act[i] <= '0;
        mult_set[i] <= CMAX;
        mult_act[i] <= CMAX;
      end
    end else begin
      if (set_we) begin
        mask_set[set_type] <= set_mask;
        mult_set[set_type] <= set_mult;
      end
      if (upd_stb) begin
        for (int i = 0; i < 4; i++) begin
          mask_act[i] <= mask_set[i];
          mult_act[i] <= mult_set[i];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= IDLE;
      sel       <= '0;
      stat      <= '0;
      bad_seen  <= 1'b0;
      abort_out <= '0;
      abort_any <= 1'b0;
      svc_irq   <= 1'b0;
      hist_we   <= 1'b0;
      hist_addr <= '0;
      hist_data <= '0;
      for (int i = 0; i < 4; i++) cnt[i] <= '0;
    end else begin
      hist_we <= 1'b0;
      case (state)
        IDLE: begin
          if (meas_stb) begin
            state    <= SCAN;
            sel      <= '0;
            bad_seen <= 1'b0;
            for (int i = 0; i < 4; i++) cnt[i] <= '0;
          end
        end
        SCAN: begin
          for (int i = 0; i < 4; i++)
            if (hit[i] && cnt[i] != CMAX) cnt[i] <= cnt[i] + 6'd1;
          if (!chan_ok) bad_seen <= 1'b1;
          stat[{sel[1:0], 2'b00} +: 4] <= req_ok;
          if (sel[1:0] == 2'd3) begin
            hist_we   <= 1'b1;
            hist_addr <= AW'(sel >> 2);
            hist_data <= {req_ok, stat[11:0]};
          end
          if (sel == SELW'(NCH - 1)) begin
            state <= SUM1;
            sel   <= '0;
          end else begin
            sel <= sel + 1'b1;
          end
        end
        SUM1: begin
          abort_out <= ab_next;
          abort_any <= |ab_next;
          svc_irq   <= bad_seen;
          hist_we   <= 1'b1;
          hist_addr <= AW'(NGRP);
          hist_data <= {cnt[1], cnt[0], ab_next};
          state     <= SUM2;
        end
        default: begin
          hist_we   <= 1'b1;
          hist_addr <= AW'(NGRP + 1);
          hist_data <= {cnt[3], cnt[2], 4'b0000};
          state     <= IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/abort_mult_poller_chk.sv
module abort_mult_poller_chk #(
  parameter int NCH = 64
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       scanning,
  input logic [$clog2(NCH)-1:0]     chan_sel,
  input logic [3:0]                 abort_out,
  input logic                       abort_any,
  input logic                       svc_irq,
  input logic                       hist_we,
  input logic [$clog2(NCH/4+2)-1:0] hist_addr,
  input logic [15:0]                hist_data
);
  localparam int SELW = $clog2(NCH);
  localparam int AW   = $clog2(NCH/4 + 2);
  localparam logic [AW-1:0] S1 = AW'(NCH/4);
  localparam logic [AW-1:0] S2 = AW'(NCH/4 + 1);

  // R1
  sel_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scanning && $past(scanning) |-> chan_sel == SELW'($past(chan_sel) + 1'b1));

  // R1
  sel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !scanning && !$past(scanning) |-> chan_sel == '0);

  // R3
  any_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_any == |abort_out);

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hist_we && hist_addr == S1) |-> $stable(abort_out) && $stable(svc_irq));

  // R8
  sum_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hist_we && hist_addr == S1 |-> hist_data[3:0] == abort_out);

  // R7
  addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hist_we |-> hist_addr <= S2);
endmodule

bind abort_mult_poller abort_mult_poller_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .scanning(scanning), .chan_sel(chan_sel),
  .abort_out(abort_out), .abort_any(abort_any), .svc_irq(svc_irq),
  .hist_we(hist_we), .hist_addr(hist_addr), .hist_data(hist_data)
);

// File: tb/abort_mult_poller_tb.sv
`timescale 1ns/1ps
module abort_mult_poller_tb;
  localparam int NCH = 64;
  localparam int NGRP = NCH / 4;
  localparam int AW = $clog2(NGRP + 2);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic meas_stb = 1'b0, upd_stb = 1'b0, set_we = 1'b0;
  logic [1:0] set_type = '0;
  logic [NCH-1:0] set_mask = '0;
  logic [5:0] set_mult = '0;
  logic [5:0] chan_sel;
  logic [3:0] abort_n;
  logic chan_ok;
  logic [3:0] abort_out;
  logic abort_any, svc_irq, hist_we;
  logic [AW-1:0] hist_addr;
  logic [15:0] hist_data;

  always #2 clk = ~clk;

  logic [3:0] req_m [NCH];
  logic       ok_m  [NCH];
  assign abort_n = ~req_m[chan_sel];
  assign chan_ok = ok_m[chan_sel];

  abort_mult_poller #(.NCH(NCH)) u_dut (
    .clk(clk), .rst_n(rst_n), .meas_stb(meas_stb), .upd_stb(upd_stb),
    .set_we(set_we), .set_type(set_type), .set_mask(set_mask), .set_mult(set_mult),
    .chan_sel(chan_sel), .abort_n(abort_n), .chan_ok(chan_ok),
    .abort_out(abort_out), .abort_any(abort_any), .svc_irq(svc_irq),
    .hist_we(hist_we), .hist_addr(hist_addr), .hist_data(hist_data)
  );

  int nchk = 0, nerr = 0;
  bit done = 0;
  logic [AW-1:0] q_addr [$];
  logic [15:0]   q_data [$];
  logic [NCH-1:0] m_set [4], m_act [4];
  int u_set [4], u_act [4];
  logic [3:0] prev_ab = '0;
  logic prev_irq = 1'b0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && hist_we) begin
      if (q_addr.size() == 0) begin
        check("R9 unexpected history word", {16'h0, hist_data}, 32'hdead);
      end else begin
        logic [AW-1:0] ea;
        logic [15:0] ed;
        ea = q_addr.pop_front();
        ed = q_data.pop_front();
        check("R7 R8 history address", 32'(hist_addr), 32'(ea));
        check(ea < AW'(NGRP) ? "R7 status word" : "R8 summary word", 32'(hist_data), 32'(ed));
      end
    end
  end

  task automatic write_set(input int t, input logic [NCH-1:0] m, input int mult);
    @(negedge clk);
    set_we = 1'b1; set_type = 2'(t); set_mask = m; set_mult = 6'(mult);
    @(negedge clk);
    set_we = 1'b0;
    m_set[t] = m; u_set[t] = mult;
  endtask

  task automatic update();
    @(negedge clk);
    upd_stb = 1'b1;
    @(negedge clk);
    upd_stb = 1'b0;
    for (int i = 0; i < 4; i++) begin m_act[i] = m_set[i]; u_act[i] = u_set[i]; end
  endtask

  task automatic run_scan(input string name, input bit extra_stb, input bit hold_chk);
    int c [4];
    logic [15:0] w [NGRP];
    logic [3:0] ab;
    logic bad;
    bad = 1'b0;
    for (int t = 0; t < 4; t++) c[t] = 0;
    for (int g = 0; g < NGRP; g++) w[g] = '0;
    for (int ch = 0; ch < NCH; ch++) begin
      logic [3:0] b;
      b = ok_m[ch] ? req_m[ch] : 4'b0;
      if (!ok_m[ch]) bad = 1'b1;
      w[ch/4][4*(ch%4) +: 4] = b;
      for (int t = 0; t < 4; t++)
        if (b[t] && m_act[t][ch] && c[t] < 63) c[t]++;
    end
    for (int t = 0; t < 4; t++) ab[t] = (c[t] >= u_act[t]);
    for (int g = 0; g < NGRP; g++) begin q_addr.push_back(AW'(g)); q_data.push_back(w[g]); end
    q_addr.push_back(AW'(NGRP));
    q_data.push_back({6'(c[1]), 6'(c[0]), ab});
    q_addr.push_back(AW'(NGRP + 1));
    q_data.push_back({6'(c[3]), 6'(c[2]), 4'b0});
    @(negedge clk); meas_stb = 1'b1;
    @(negedge clk); meas_stb = 1'b0;
    repeat (10) @(negedge clk);
    if (extra_stb) begin
      meas_stb = 1'b1;
      @(negedge clk); meas_stb = 1'b0;
    end
    if (hold_chk) begin
      check({"R9 hold abort_out mid-pass ", name}, 32'(abort_out), 32'(prev_ab));
      check({"R9 hold svc_irq mid-pass ", name}, 32'(svc_irq), 32'(prev_irq));
    end
    repeat (70) @(negedge clk);
    check({"R3 abort_out ", name}, 32'(abort_out), 32'(ab));
    check({"R3 abort_any ", name}, 32'(abort_any), 32'(|ab));
    check({"R5 svc_irq ", name}, 32'(svc_irq), 32'(bad));
    check({"R9 record complete ", name}, 32'(q_addr.size()), 32'd0);
    q_addr.delete(); q_data.delete();
    prev_ab = ab; prev_irq = bad;
  endtask

  task automatic clear_bus();
    for (int ch = 0; ch < NCH; ch++) begin req_m[ch] = 4'b0; ok_m[ch] = 1'b1; end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    logic [NCH-1:0] evens;
    int seed;
    clear_bus();
    for (int i = 0; i < 4; i++) begin m_set[i] = '0; m_act[i] = '0; u_set[i] = 63; u_act[i] = 63; end
    repeat (3) @(negedge clk);
    check("R10 chan_sel in reset", 32'(chan_sel), 0);
    check("R10 abort_out in reset", 32'(abort_out), 0);
    check("R10 abort_any in reset", 32'(abort_any), 0);
    check("R10 svc_irq in reset", 32'(svc_irq), 0);
    check("R10 hist_we in reset", 32'(hist_we), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 chan_sel idle", 32'(chan_sel), 0);

    // R6 reset settings: all masked, threshold 63
    for (int ch = 0; ch < 8; ch++) req_m[ch] = 4'hf;
    run_scan("reset settings R6", 0, 0);

    // R2 R3 thresholds: equal, above, single top channel, zero
    clear_bus();
    evens = '0;
    for (int ch = 0; ch < NCH; ch += 2) evens[ch] = 1'b1;
    write_set(0, '1, 5);
    write_set(1, evens, 6);
    write_set(2, NCH'(1) << (NCH-1), 1);
    write_set(3, '0, 0);
    update();
    for (int ch = 0; ch < 5; ch++) req_m[ch][0] = 1'b1;
    for (int ch = 10; ch < 20; ch++) req_m[ch][1] = 1'b1;
    req_m[63][2] = 1'b1;
    req_m[62][2] = 1'b1;
    run_scan("threshold cases R2", 0, 0);

    // R5 unhealthy channel dropped, R9 hold and ignored strobe
    ok_m[2] = 1'b0;
    run_scan("unhealthy channel R5", 1, 1);

    // R6 staged write without update has no effect
    ok_m[2] = 1'b1;
    write_set(0, '1, 6);
    write_set(1, '1, 1);
    run_scan("staged only R6", 0, 1);
    update();
    run_scan("after update R6", 0, 0);

    // R4 saturation
    for (int ch = 0; ch < NCH; ch++) req_m[ch] = 4'hf;
    for (int t = 0; t < 4; t++) write_set(t, '1, 63);
    update();
    run_scan("saturation R4", 0, 1);

    // R2 R7 pseudo-random patterns
    seed = 32'h1234_5678;
    for (int k = 0; k < 4; k++) begin
      for (int ch = 0; ch < NCH; ch++) begin
        seed = seed * 1103515245 + 12345;
        req_m[ch] = 4'(seed >> 16);
        ok_m[ch] = ((seed >> 24) & 15) != 0;
      end
      for (int t = 0; t < 4; t++) begin
        seed = seed * 1103515245 + 12345;
        write_set(t, {NCH/32{32'(seed) ^ 32'h5a5a_0f0f}}, (seed >> 20) & 31);
      end
      update();
      run_scan("pattern R2 R7", k[0], 1);
    end

    report();
  end
endmodule